// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the serial clock of an I2C master from a fast functional clock. A programmable prescaler first derives a slower internal tick. The clock line is then driven low for a programmed number of ticks and released for another programmed number. Each phase has a fixed minimum built into its count: the low phase is seven ticks longer than its register value and the high phase is five ticks longer.

The low-time and high-time registers are packed with two rates each. The lower byte holds the standard/fast setting and the upper byte holds the high-speed setting. A transfer always begins on the lower-byte timing. When high-speed mode is selected, the bus engine pulses a phase input once the master-code byte and its not-acknowledge bit are done. From the next low phase onward the generator then uses the upper-byte timing.

The high-phase count only advances while the sensed line is actually high, so a slave can stretch the clock. Prescaler and timing values are captured at the start of every low phase and held until the next one. Generating start and stop conditions and shifting data belong to the neighbouring bus engine.

Top module: `scl_timing_gen`

## Requirements
- R1: While `mod_en` is 0 (including during reset), `scl_o` is 1 and stays 1 whatever `xfer_start` does. After `mod_en` rises, `scl_o` stays 1 until an `xfer_start` pulse arrives.
- R2: A one-cycle `xfer_start` pulse while `mod_en` is 1 makes `scl_o` 0 from the next clock cycle.
- R3: On the standard/fast timing, each low phase lasts (L+7)*(P+1) clock cycles. L is bits 7:0 of `scl_low_reg` and P is `psc_reg`.
- R4: On the standard/fast timing, each high phase lasts (H+5)*(P+1) clock cycles when the line is not held low. H is bits 7:0 of `scl_high_reg`.
- R5: During the high phase, each cycle in which `scl_in` is 0 while `scl_o` is 1 lengthens the high phase by one clock cycle.
- R6: With `hs_mode` 1, an `hs_phase_go` pulse switches timing at the start of the following low phase. From then on, L and H are taken from bits 15:8 of the two registers.
- R7: With `hs_mode` 0, `hs_phase_go` has no effect and bits 7:0 stay in use.
- R8: Changes to `psc_reg`, `scl_low_reg` and `scl_high_reg` take effect only at the next low-phase start. A high phase uses the values captured at the start of the low phase before it.
- R9: An `xfer_start` pulse during a running transfer restarts a full low phase on the standard/fast timing and cancels any earlier `hs_phase_go`.
- R10: Low and high phases alternate without gaps for as long as `mod_en` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_en | input | 1 | Module enable from the control register |
| hs_mode | input | 1 | High-speed mode select from the control register |
| psc_reg | input | PSC_W | Prescaler value P; internal tick is clk/(P+1) |
| scl_low_reg | input | 2*TIME_W | Low-time values: high-speed byte above, standard/fast byte below |
| scl_high_reg | input | 2*TIME_W | High-time values: high-speed byte above, standard/fast byte below |
| xfer_start | input | 1 | Pulse that begins a transfer with the first low phase |
| hs_phase_go | input | 1 | Pulse from the bus engine when the master-code phase is over |
| scl_in | input | 1 | Sensed level of the clock line |
| scl_o | output | 1 | Clock line drive: 0 pulls low, 1 releases |

## Verification
The bench builds the block with its default widths: an 8-bit prescaler and 8-bit timing bytes. At these widths the full byte value 255 is reachable, and it needs the ninth bit of the phase limit (262 ticks low, 260 high). Prescaler values are kept to 0..3 so that the exact products of phase length and prescale can be checked on many patterns at short run time. Stretching is exercised by holding the sensed line low from the bench at the start of a high phase.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

  typedef enum logic [1:0] {
    SG_IDLE = 2'd0,
    SG_LOW  = 2'd1,
    SG_HIGH = 2'd2
  } sg_state_e;

  // fixed tick counts added on top of the programmed phase values
  localparam int unsigned LOW_EXTRA  = 7;
  localparam int unsigned HIGH_EXTRA = 5;

endpackage

// File: rtl/scl_rst_sync.sv
module scl_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_s = sync_q[1];

endmodule

// File: rtl/scl_presc.sv
module scl_presc #(
  parameter int PSC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);

  logic [PSC_W-1:0] cnt_q;
  logic [PSC_W-1:0] cnt_d;
  logic             at_top;

  assign at_top = (cnt_q == div);
  assign tick   = run & at_top;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (run) begin
      cnt_d = at_top ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/scl_phase_cnt.sv
module scl_phase_cnt #(
  parameter int LIM_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [LIM_W-1:0] limit,
  output logic             done
);

  logic [LIM_W-1:0] cnt_q;
  logic [LIM_W-1:0] cnt_d;
  logic             last;

  assign last = (cnt_q == limit - 1'b1);
  assign done = tick & last;

  always_comb begin
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (tick) begin
      cnt_d = last ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/scl_time_latch.sv
module scl_time_latch
  import scl_gen_pkg::*;
#(
  parameter int TIME_W = 8,
  parameter int PSC_W  = 8,
  parameter int LIM_W  = TIME_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                use_hs,
  input  logic [2*TIME_W-1:0] low_reg,
  input  logic [2*TIME_W-1:0] high_reg,
  input  logic [PSC_W-1:0]    psc_reg,
  output logic [LIM_W-1:0]    low_lim,
  output logic [LIM_W-1:0]    high_lim,
  output logic [PSC_W-1:0]    div
);

  logic [TIME_W-1:0] low_sel;
  logic [TIME_W-1:0] high_sel;
  logic [LIM_W-1:0]  low_lim_d;
  logic [LIM_W-1:0]  high_lim_d;

  // byte select: upper byte carries the high-speed timing
  assign low_sel  = use_hs ? low_reg[2*TIME_W-1:TIME_W]  : low_reg[TIME_W-1:0];
  assign high_sel = use_hs ? high_reg[2*TIME_W-1:TIME_W] : high_reg[TIME_W-1:0];

  assign low_lim_d  = {1'b0, low_sel}  + LIM_W'(LOW_EXTRA);
  assign high_lim_d = {1'b0, high_sel} + LIM_W'(HIGH_EXTRA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_lim  <= LIM_W'(LOW_EXTRA);
      high_lim <= LIM_W'(HIGH_EXTRA);
      div      <= '0;
    end else if (load) begin
      low_lim  <= low_lim_d;
      high_lim <= high_lim_d;
      div      <= psc_reg;
    end
  end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
  import scl_gen_pkg::*;
#(
  parameter int PSC_W  = 8,
  parameter int TIME_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mod_en,
  input  logic                hs_mode,
  input  logic [PSC_W-1:0]    psc_reg,
  input  logic [2*TIME_W-1:0] scl_low_reg,
  input  logic [2*TIME_W-1:0] scl_high_reg,
  input  logic                xfer_start,
  input  logic                hs_phase_go,
  input  logic                scl_in,
  output logic                scl_o
);

  localparam int LIM_W = TIME_W + 1;

  logic             rst_n_s;
  sg_state_e        state_q;
  sg_state_e        state_d;
  logic             ph2_q;
  logic             ph2_d;
  logic             load;
  logic             clr;
  logic             use_hs;
  logic             run;
  logic             tick;
  logic             phase_done;
  logic [LIM_W-1:0] low_lim;
  logic [LIM_W-1:0] high_lim;
  logic [LIM_W-1:0] limit;
  logic [PSC_W-1:0] div;

  scl_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  // timing captured only when a low phase begins
  assign use_hs = hs_mode & ph2_q & ~xfer_start;

  scl_time_latch #(
    .TIME_W (TIME_W),
    .PSC_W  (PSC_W),
    .LIM_W  (LIM_W)
  ) u_latch (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .load     (load),
    .use_hs   (use_hs),
    .low_reg  (scl_low_reg),
    .high_reg (scl_high_reg),
    .psc_reg  (psc_reg),
    .low_lim  (low_lim),
    .high_lim (high_lim),
    .div      (div)
  );

  // high-phase ticks are held while the line is pulled low by a slave
  assign run = (state_q == SG_LOW) | ((state_q == SG_HIGH) & scl_in);

  scl_presc #(
    .PSC_W (PSC_W)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (clr),
    .run   (run),
    .div   (div),
    .tick  (tick)
  );

  assign limit = (state_q == SG_LOW) ? low_lim : high_lim;

  scl_phase_cnt #(
    .LIM_W (LIM_W)
  ) u_phase (
    .clk   (clk),
    .rst_n (rst_n_s),
    .clr   (clr),
    .tick  (tick),
    .limit (limit),
    .done  (phase_done)
  );

  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    clr     = 1'b0;
    ph2_d   = ph2_q | hs_phase_go;
    if (!mod_en) begin
      state_d = SG_IDLE;
      clr     = 1'b1;
      ph2_d   = 1'b0;
    end else if (xfer_start) begin
      state_d = SG_LOW;
      load    = 1'b1;
      clr     = 1'b1;
      ph2_d   = 1'b0;
    end else begin
      case (state_q)
        SG_LOW: begin
          if (phase_done) begin
            state_d = SG_HIGH;
            clr     = 1'b1;
          end
        end
        SG_HIGH: begin
          if (phase_done) begin
            state_d = SG_LOW;
            load    = 1'b1;
            clr     = 1'b1;
          end
        end
        default: begin
          clr = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= SG_IDLE;
      ph2_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      ph2_q   <= ph2_d;
    end
  end

  assign scl_o = (state_q != SG_LOW);

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic mod_en,
  input logic xfer_start,
  input logic scl_in,
  input logic scl_o
);

  // R1: disabled module releases the line on the next cycle
  p_released_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !mod_en |=> scl_o);

  // R2: start while enabled pulls the line low next cycle
  p_start_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en && xfer_start) |=> !scl_o);

  // R3: a low phase never lasts a single cycle
  p_low_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_o) && mod_en) |=> !scl_o);

  // R4: a high phase never lasts a single cycle
  p_high_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_o) && mod_en && !xfer_start) |=> scl_o);

  // R5: a held-low line freezes the high phase
  p_stretch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && !scl_in && mod_en && !xfer_start) |=> scl_o);

endmodule

bind scl_timing_gen scl_timing_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n_s),
  .mod_en     (mod_en),
  .xfer_start (xfer_start),
  .scl_in     (scl_in),
  .scl_o      (scl_o)
);

// File: tb/scl_timing_gen_tb.sv
`timescale 1ns/1ps
module scl_timing_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_en = 1'b0;
  logic        hs_mode = 1'b0;
  logic [7:0]  psc_reg = '0;
  logic [15:0] scl_low_reg = '0;
  logic [15:0] scl_high_reg = '0;
  logic        xfer_start = 1'b0;
  logic        hs_phase_go = 1'b0;
  logic        stretch = 1'b0;
  logic        scl_in;
  logic        scl_o;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  assign scl_in = scl_o & ~stretch;

  scl_timing_gen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .mod_en       (mod_en),
    .hs_mode      (hs_mode),
    .psc_reg      (psc_reg),
    .scl_low_reg  (scl_low_reg),
    .scl_high_reg (scl_high_reg),
    .xfer_start   (xfer_start),
    .hs_phase_go  (hs_phase_go),
    .scl_in       (scl_in),
    .scl_o        (scl_o)
  );

  function automatic int exp_lo(int v, int p);
    return (v + 7) * (p + 1);
  endfunction

  function automatic int exp_hi(int v, int p);
    return (v + 5) * (p + 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_regs(input int p, input int lf, input int lh,
                          input int hf, input int hh);
    psc_reg      = 8'(p);
    scl_low_reg  = {8'(lh), 8'(lf)};
    scl_high_reg = {8'(hh), 8'(hf)};
  endtask

  // returns at the negedge of the first low cycle
  task automatic do_start;
    @(negedge clk) xfer_start = 1'b1;
    @(negedge clk) xfer_start = 1'b0;
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    while (scl_o === lvl && n < 20000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic check_pair(input string req, input int lv, input int hv, input int p);
    int lo;
    int hi;
    count_level(1'b0, lo);
    count_level(1'b1, hi);
    chk({req, " low"}, lo, exp_lo(lv, p));
    chk({req, " high"}, hi, exp_hi(hv, p));
  endtask

  initial begin
    int lo;
    int hi;
    int stuck;
    int p, lf, lh, hf, hh;
    void'($urandom(32'd5113));

    repeat (3) @(negedge clk);
    chk("R1 reset releases line", int'(scl_o), 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    mod_en = 1'b1;
    repeat (20) @(negedge clk);
    chk("R1 enabled idle stays high", int'(scl_o), 1);

    // R2, R3, R4, R10: basic timing, two consecutive pairs
    set_regs(1, 2, 0, 3, 0);
    do_start();
    chk("R2 low right after start", int'(scl_o), 0);
    check_pair("R3/R4 first pair", 2, 3, 1);
    check_pair("R10 second pair", 2, 3, 1);

    // largest byte values, restart while running
    set_regs(0, 255, 0, 255, 0);
    do_start();
    check_pair("R3/R4 max byte", 255, 255, 0);

    // R8: change registers inside the first low phase
    set_regs(0, 1, 0, 1, 0);
    do_start();
    set_regs(2, 4, 0, 2, 0);
    check_pair("R8 old values kept", 1, 1, 0);
    check_pair("R8 new values", 4, 2, 2);

    // R5: stretch of 3 cycles at the start of high
    set_regs(1, 0, 0, 0, 0);
    do_start();
    count_level(1'b0, lo);
    chk("R5 low before stretch", lo, exp_lo(0, 1));
    hi = 0;
    stretch = 1'b1;
    while (scl_o === 1'b1 && hi < 20000) begin
      hi++;
      if (hi == 4) stretch = 1'b0;
      @(negedge clk);
    end
    stretch = 1'b0;
    chk("R5 stretched high", hi, exp_hi(0, 1) + 3);

    // R6: high-speed switch after the phase pulse
    hs_mode = 1'b1;
    set_regs(0, 3, 1, 2, 0);
    do_start();
    hs_phase_go = 1'b1;
    count_level(1'b0, lo);
    hs_phase_go = 1'b0;
    count_level(1'b1, hi);
    chk("R6 first low fast", lo, exp_lo(3, 0));
    chk("R6 first high fast", hi, exp_hi(2, 0));
    check_pair("R6 switched pair", 1, 0, 0);

    // R9: restart cancels the switch
    do_start();
    check_pair("R9 restart fast", 3, 2, 0);
    check_pair("R9 stays fast", 3, 2, 0);

    // R7: phase pulse without high-speed mode
    hs_mode = 1'b0;
    do_start();
    hs_phase_go = 1'b1;
    check_pair("R7 first pair", 3, 2, 0);
    hs_phase_go = 1'b0;
    check_pair("R7 still fast", 3, 2, 0);

    // R1: disable in the middle of a low phase
    set_regs(1, 6, 0, 6, 0);
    do_start();
    repeat (3) @(negedge clk);
    mod_en = 1'b0;
    @(negedge clk);
    chk("R1 disable releases", int'(scl_o), 1);
    stuck = 0;
    xfer_start = 1'b1;
    repeat (50) begin
      @(negedge clk);
      if (scl_o !== 1'b1) stuck++;
    end
    xfer_start = 1'b0;
    chk("R1 start ignored while off", stuck, 0);
    mod_en = 1'b1;
    stuck = 0;
    repeat (30) begin
      @(negedge clk);
      if (scl_o !== 1'b1) stuck++;
    end
    chk("R1 idle until start", stuck, 0);
    do_start();
    check_pair("R3/R4 fresh after re-enable", 6, 6, 1);

    // random patterns, R3/R4/R6/R7
    for (int i = 0; i < 12; i++) begin
      p  = int'($urandom_range(3, 0));
      lf = int'($urandom_range(31, 0));
      lh = int'($urandom_range(31, 0));
      hf = int'($urandom_range(31, 0));
      hh = int'($urandom_range(31, 0));
      hs_mode = 1'($urandom_range(1, 0));
      set_regs(p, lf, lh, hf, hh);
      do_start();
      hs_phase_go = 1'b1;
      count_level(1'b0, lo);
      hs_phase_go = 1'b0;
      count_level(1'b1, hi);
      chk("R3 random first low", lo, exp_lo(lf, p));
      chk("R4 random first high", hi, exp_hi(hf, p));
      if (hs_mode) check_pair("R6 random switched", lh, hh, p);
      else         check_pair("R7 random unswitched", lf, hf, p);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule